// File: doc/BRIEF.md
# Load/Store-Multiple Address Sequencer

This block expands one block-transfer request into an ordered series of single-word memory accesses. A request carries a base address, a register-select mask (one bit per architectural register), a direction flag that picks load or store, an addressing mode and a writeback flag. The mode is either ascending-from-base or descending-below-base. Once the request is taken, the block presents one access at a time. Each access carries the register index, the word address and a read or write strobe. The block moves to the next access whenever the memory side signals ready.

The registers are always visited from the lowest index to the highest, and lower indices always get lower addresses. In ascending mode the first access sits at the base and each later one is 4 bytes higher. In descending mode the whole group sits in the words directly below the base. After the final acknowledged access the block raises a one-cycle completion pulse. If writeback was requested, it raises a writeback enable in the same cycle, together with the updated base. The usual stack idioms map onto the modes: a full-descending pop and an empty-ascending push use the ascending mode, and a full-descending push and an empty-ascending pop use the descending mode. An empty mask is refused with a one-cycle error pulse, and no access is issued for it.

Top module: `lsm_seq`

## Requirements
- R1: After reset the block is idle: req_ready is 1, and acc_valid, acc_read, acc_write, done, err and wb_en are all 0.
- R2: For a mask with n set bits, exactly n accesses are presented, one per set bit, with acc_idx taking the set-bit positions in strictly ascending order.
- R3: In ascending mode (req_mode = 0) the k-th access (k from 0) uses address base + 4*k.
- R4: In descending mode (req_mode = 1) the k-th access uses address base - 4*n + 4*k, so the last access uses base - 4. Addresses wrap modulo 2^ADDR_W.
- R5: While acc_valid is 1, exactly one strobe is set: acc_read when req_load was 1, and acc_write when req_load was 0.
- R6: An access whose mem_ready is 0 at a clock edge is held unchanged into the next cycle. The first access appears in the cycle after acceptance, and each acknowledgement moves to the next access in the following cycle.
- R7: done is 1 for exactly one cycle, in the cycle after the edge at which the last access is acknowledged, and acc_valid is 0 in that cycle.
- R8: wb_en is 1 only together with done, and only when req_wb was 1. With it, wb_value is base + 4*n in ascending mode and base - 4*n in descending mode.
- R9: A request with an all-zero mask produces err = 1 for exactly the next cycle, starts no access and leaves the block idle.
- R10: A request is accepted only while req_ready is 1. req_valid during a transfer is ignored and does not disturb the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_base | input | ADDR_W | Base address |
| req_mask | input | NREG | Register-select mask, bit i selects register i |
| req_load | input | 1 | 1 = load (read), 0 = store (write) |
| req_mode | input | 1 | 0 = ascending from base, 1 = descending below base |
| req_wb | input | 1 | Request base writeback |
| req_ready | output | 1 | Idle, a request is taken this cycle |
| acc_valid | output | 1 | Access presented |
| acc_read | output | 1 | Read strobe |
| acc_write | output | 1 | Write strobe |
| acc_idx | output | IDX_W | Register index of the access |
| acc_addr | output | ADDR_W | Word address of the access |
| mem_ready | input | 1 | Memory accepts the presented access |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for an empty mask |
| wb_en | output | 1 | Base writeback enable |
| wb_value | output | ADDR_W | Updated base value |

## Verification
The bench targets the masks where skipping and ordering go wrong: single bits at either end, the full mask, sparse masks and the empty mask. A priority encoder that favours the wrong end would reverse the index order. An off-by-one in the remaining mask would drop or repeat a register. The bench also runs the descending mode near address zero, where a start computed as base - 4*(n-1) or a reversed walk would give wrong addresses. It stalls mem_ready at random and raises req_valid in the middle of transfers. A design that advanced without ready, or that took a new request while busy, would present the wrong access or emit an extra done or writeback.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_t;

  localparam logic MODE_ASCEND  = 1'b0;
  localparam logic MODE_DESCEND = 1'b1;
endpackage

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
  parameter int W    = 16,
  parameter int IW   = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
    any = |vec;
  end
endmodule

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] part [W+1];
  assign part[0] = '0;
  for (genvar g = 0; g < W; g++) begin : g_acc
    assign part[g+1] = part[g] + CW'(vec[g]);
  end
  assign cnt = part[W];
endmodule

// File: rtl/lsm_addr_calc.sv
module lsm_addr_calc #(
  parameter int ADDR_W = 32,
  parameter int CW     = 5
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [CW-1:0]     cnt,
  input  logic              mode,
  output logic [ADDR_W-1:0] first_addr,
  output logic [ADDR_W-1:0] final_base
);
  import lsm_pkg::*;
  logic [ADDR_W-1:0] span;
  assign span = ADDR_W'(cnt) << 2;

  always_comb begin
    if (mode == MODE_DESCEND) begin
      first_addr = base - span;
      final_base = base - span;
    end else begin
      first_addr = base;
      final_base = base + span;
    end
  end
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq #(
  parameter int ADDR_W = 32,
  parameter int NREG   = 16,
  parameter int IDX_W  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [NREG-1:0]   req_mask,
  input  logic              req_load,
  input  logic              req_mode,
  input  logic              req_wb,
  output logic              req_ready,
  output logic              acc_valid,
  output logic              acc_read,
  output logic              acc_write,
  output logic [IDX_W-1:0]  acc_idx,
  output logic [ADDR_W-1:0] acc_addr,
  input  logic              mem_ready,
  output logic              done,
  output logic              err,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_value
);
  import lsm_pkg::*;
  localparam int CW = $clog2(NREG + 1);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

  seq_state_t        state_q;
  logic [NREG-1:0]   rem_q;
  logic              load_q, wbreq_q;
  logic [ADDR_W-1:0] addr_q, wbval_q;
  logic [IDX_W-1:0]  idx_q;
  logic              done_q, err_q, wben_q;

  logic [CW-1:0]     req_cnt;
  logic [ADDR_W-1:0] first_addr, final_base;
  logic [IDX_W-1:0]  req_low, nxt_low;
  logic              req_any, nxt_any;
  logic [NREG-1:0]   nxt_rem;
  logic              accept, step;

  lsm_popcnt #(.W(NREG), .CW(CW)) u_cnt (.vec(req_mask), .cnt(req_cnt));

  lsm_addr_calc #(.ADDR_W(ADDR_W), .CW(CW)) u_addr (
    .base(req_base), .cnt(req_cnt), .mode(req_mode),
    .first_addr(first_addr), .final_base(final_base)
  );

  lsm_lowbit #(.W(NREG), .IW(IDX_W)) u_req_low (
    .vec(req_mask), .idx(req_low), .any(req_any)
  );

  assign nxt_rem = rem_q & ~(NREG'(1) << idx_q);

  lsm_lowbit #(.W(NREG), .IW(IDX_W)) u_nxt_low (
    .vec(nxt_rem), .idx(nxt_low), .any(nxt_any)
  );

  assign accept = (state_q == SEQ_IDLE) && req_valid;
  assign step   = (state_q == SEQ_BUSY) && mem_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      rem_q   <= '0;
      load_q  <= 1'b0;
      wbreq_q <= 1'b0;
      addr_q  <= '0;
      wbval_q <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      wben_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      wben_q <= 1'b0;
      if (accept) begin
        if (!req_any) begin
          err_q <= 1'b1;
        end else begin
          state_q <= SEQ_BUSY;
          rem_q   <= req_mask;
          idx_q   <= req_low;
          addr_q  <= first_addr;
          wbval_q <= final_base;
          load_q  <= req_load;
          wbreq_q <= req_wb;
        end
      end else if (step) begin
        rem_q  <= nxt_rem;
        addr_q <= addr_q + WORD_STEP;
        idx_q  <= nxt_low;
        if (!nxt_any) begin
          state_q <= SEQ_IDLE;
          done_q  <= 1'b1;
          wben_q  <= wbreq_q;
        end
      end
    end
  end

  assign req_ready = (state_q == SEQ_IDLE);
  assign acc_valid = (state_q == SEQ_BUSY);
  assign acc_read  = acc_valid && load_q;
  assign acc_write = acc_valid && !load_q;
  assign acc_idx   = idx_q;
  assign acc_addr  = addr_q;
  assign done      = done_q;
  assign err       = err_q;
  assign wb_en     = wben_q;
  assign wb_value  = wbval_q;

  // R2: presented index is always a still-pending register
  a_r2_idx_pending: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> rem_q[acc_idx]);
  // R5: one strobe per access
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> $countones({acc_read, acc_write}) == 1);
  // R6: stalled access holds
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !mem_ready |=> acc_valid && $stable(acc_addr) && $stable(acc_idx));
  // R7: done is a single-cycle pulse with no access alongside
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |-> !acc_valid ##1 !done);
  // R8: writeback only with completion
  a_r8_wb_with_done: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> done);
  // R9: error never coincides with an access
  a_r9_err_idle: assert property (@(posedge clk) disable iff (rst)
    err |-> req_ready && !acc_valid);
  // R10: remaining mask only shrinks while busy
  a_r10_busy_mask: assert property (@(posedge clk) disable iff (rst)
    acc_valid && $past(acc_valid) |-> (rem_q & ~$past(rem_q)) == '0);
endmodule

// File: tb/lsm_seq_test.sv
module lsm_seq_test;
  localparam int ADDR_W = 32;
  localparam int NREG   = 16;
  localparam int IDX_W  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_base = '0;
  logic [NREG-1:0]   req_mask = '0;
  logic              req_load = 1'b0, req_mode = 1'b0, req_wb = 1'b0;
  logic              mem_ready = 1'b0;
  logic              req_ready, acc_valid, acc_read, acc_write, done, err, wb_en;
  logic [IDX_W-1:0]  acc_idx;
  logic [ADDR_W-1:0] acc_addr, wb_value;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lsm_seq #(.ADDR_W(ADDR_W), .NREG(NREG), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_base(req_base),
    .req_mask(req_mask), .req_load(req_load), .req_mode(req_mode),
    .req_wb(req_wb), .req_ready(req_ready), .acc_valid(acc_valid),
    .acc_read(acc_read), .acc_write(acc_write), .acc_idx(acc_idx),
    .acc_addr(acc_addr), .mem_ready(mem_ready), .done(done), .err(err),
    .wb_en(wb_en), .wb_value(wb_value)
  );

  // reference model
  int                q_idx[$];
  logic [ADDR_W-1:0] q_addr[$];
  bit                m_busy = 0, m_load = 0, m_wbflag = 0;
  bit                m_done = 0, m_err = 0, m_wben = 0;
  logic [ADDR_W-1:0] m_wbval = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_err = 0; m_wben = 0;
      q_idx.delete(); q_addr.delete();
    end else begin
      m_done = 0; m_err = 0; m_wben = 0;
      if (m_busy) begin
        if (mem_ready) begin
          void'(q_idx.pop_front());
          void'(q_addr.pop_front());
          if (q_idx.size() == 0) begin
            m_busy = 0; m_done = 1; m_wben = m_wbflag;
          end
        end
      end else if (req_valid) begin
        if (req_mask == '0) m_err = 1;
        else begin
          int n;
          logic [ADDR_W-1:0] a;
          n = $countones(req_mask);
          a = req_mode ? req_base - ADDR_W'(4 * n) : req_base;
          for (int i = 0; i < NREG; i++) begin
            if (req_mask[i]) begin
              q_idx.push_back(i);
              q_addr.push_back(a);
              a = a + 4;
            end
          end
          m_wbval  = req_mode ? req_base - ADDR_W'(4 * n) : req_base + ADDR_W'(4 * n);
          m_busy   = 1;
          m_load   = req_load;
          m_wbflag = req_wb;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(req_ready == !m_busy, "R10 req_ready", req_ready, !m_busy);
    chk(acc_valid == m_busy, "R2 acc_valid", acc_valid, m_busy);
    chk(done == m_done, "R7 done", done, m_done);
    chk(err == m_err, "R9 err", err, m_err);
    chk(wb_en == m_wben, "R8 wb_en", wb_en, m_wben);
    if (m_wben) chk(wb_value == m_wbval, "R8 wb_value", wb_value, m_wbval);
    if (m_busy) begin
      chk(acc_idx == IDX_W'(q_idx[0]), "R2 acc_idx", acc_idx, q_idx[0]);
      chk(acc_addr == q_addr[0], "R3/R4 acc_addr", acc_addr, q_addr[0]);
      chk(acc_read == m_load && acc_write == !m_load, "R5 strobes",
          {acc_read, acc_write}, {m_load, !m_load});
    end else begin
      chk(!acc_read && !acc_write, "R5 idle strobes", {acc_read, acc_write}, 0);
    end
  endtask

  always @(negedge clk) if (!rst) compare();

  task automatic drive(input logic [NREG-1:0] m, input logic [ADDR_W-1:0] b,
                       input bit ld, input bit md, input bit wb);
    req_valid = 1; req_mask = m; req_base = b;
    req_load = ld; req_mode = md; req_wb = wb;
  endtask

  task automatic run_req(input logic [NREG-1:0] m, input logic [ADDR_W-1:0] b,
                         input bit ld, input bit md, input bit wb);
    while (!req_ready) @(negedge clk);
    drive(m, b, ld, md, wb);
    @(negedge clk);
    req_valid = 0;
    while (!req_ready) begin
      mem_ready = ($urandom_range(0, 3) != 0);
      @(negedge clk);
    end
    mem_ready = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1, "R1 req_ready", req_ready, 1);
    chk(!acc_valid && !acc_read && !acc_write, "R1 acc", acc_valid, 0);
    chk(!done && !err && !wb_en, "R1 pulses", {done, err, wb_en}, 0);
    rst = 0;
    @(negedge clk);
    // R3 ascending, sparse mask, load with writeback
    run_req(16'h8421, 32'h0000_1000, 1, 0, 1);
    // R4 descending, store, full mask, near zero (wrap)
    run_req(16'hFFFF, 32'h0000_0010, 0, 1, 1);
    // R2 single ends
    run_req(16'h0001, 32'h2000_0000, 1, 1, 1);
    run_req(16'h8000, 32'h2000_0000, 0, 0, 0);
    // R9 empty mask
    run_req(16'h0000, 32'h3000_0000, 1, 0, 1);
    @(negedge clk);
    // R6 long stall with R10 request noise while busy
    while (!req_ready) @(negedge clk);
    drive(16'h0C30, 32'h4000_0100, 1, 1, 0);
    @(negedge clk);
    drive(16'hFFFF, 32'h5555_0000, 0, 0, 1);
    mem_ready = 0;
    repeat (6) @(negedge clk);
    req_valid = 0;
    while (!req_ready) begin
      mem_ready = ($urandom_range(0, 1) != 0);
      @(negedge clk);
    end
    mem_ready = 0;
    // random traffic
    for (int t = 0; t < 4000; t++) begin
      logic [NREG-1:0] m;
      case ($urandom_range(0, 5))
        0: m = '0;
        1: m = NREG'(1) << $urandom_range(0, NREG - 1);
        2: m = '1;
        default: m = NREG'($urandom);
      endcase
      req_valid = ($urandom_range(0, 2) != 0);
      req_mask  = m;
      req_base  = {$urandom, 2'b00} >> 0;
      req_base[1:0] = 2'b00;
      req_load  = $urandom_range(0, 1) != 0;
      req_mode  = $urandom_range(0, 1) != 0;
      req_wb    = $urandom_range(0, 1) != 0;
      mem_ready = ($urandom_range(0, 2) != 0);
      @(negedge clk);
    end
    req_valid = 0;
    mem_ready = 1;
    repeat (40) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule